// File: doc/BRIEF.md
# Two-Word Pointer Literal Loader

This block carries out one instruction that places a 12-bit unsigned constant (0 to 4095) into one of three indirect-address pointer registers. Each pointer is stored as a high byte and a low byte. The instruction takes two consecutive 16-bit words. The opening word names the target pointer and carries the top four literal bits. The closing word carries the low eight bits.

The high byte is committed on the clock edge that accepts the opening word. The low byte is committed on the edge that accepts the closing word. Between the two words the block holds the chosen pointer index and raises `busy`. The instruction changes no flags. The block does only this decode, the two byte writes and the state that spans the two words. Instruction fetch, other opcodes and the memory accesses that use the pointers sit outside it.

Top module: `ptr_literal_loader`

## Requirements
- R1: A synchronous reset clears every pointer byte, drops `busy` and drops `sel_err`.
- R2: An accepted word of the form 1110_1110_00ss_hhhh, with ss below 3, sets high byte ss to {0000, hhhh} on that edge. Every other byte keeps its value, and the upper nibble of a high byte is always zero.
- R3: `busy` goes high on the edge that accepts a legal opening word. It stays high until the next accepted word.
- R4: An accepted word of the form 1111_0000_llll_llll while `busy` is high sets low byte ss (the index held from the opening word) to llll_llll and clears `busy`.
- R5: Loading the constant 0x3AB into pointer 2 leaves its high byte at 0x03 and its low byte at 0xAB.
- R6: An opening word with ss = 3 changes no pointer byte and leaves `busy` low. It raises `sel_err` for exactly the one following cycle.
- R7: A word whose top nibble is 1111, accepted while `busy` is low, changes no pointer byte and leaves `busy` low.
- R8: A cycle with `instr_valid` low changes no pointer byte and does not change `busy`.
- R9: While `busy` is high, an accepted word that is not the closing form ends the pending load and leaves the low byte unchanged. That word is then decoded as a fresh word, so an opening word starts a new load.
- R10: `sel_err` is low in every cycle except the one that follows an illegal opening word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Qualifies `instr_word` in this cycle |
| instr_word | input | 16 | Instruction word |
| ptr_hi | output | PTR_COUNT x 8 | High bytes of the pointers, index 0 in the low byte |
| ptr_lo | output | PTR_COUNT x 8 | Low bytes of the pointers, index 0 in the low byte |
| busy | output | 1 | High between an accepted opening word and the word that follows it |
| sel_err | output | 1 | One-cycle pulse after an opening word that names pointer 3 |

## Verification
A wrong held index shows up as a low byte landing in the wrong pointer. That error is visible on the ports one cycle after the closing word. A stuck or spurious pending state shows as a wrong `busy` level within a cycle. It also shows as a low byte written by a stray 1111 word or by a word that follows a cancelled load. The bench sweeps every literal into every pointer. After each word it compares all six bytes, `busy` and `sel_err` against a model, so any such fault is caught on the cycle it first appears.

// File: rtl/ptr_literal_loader.sv
module ptr_literal_loader #(
  parameter int PTR_COUNT = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      instr_valid,
  input  logic [15:0]               instr_word,
  output logic [PTR_COUNT-1:0][7:0] ptr_hi,
  output logic [PTR_COUNT-1:0][7:0] ptr_lo,
  output logic                      busy,
  output logic                      sel_err
);
  localparam int SEL_W = 2;
  localparam logic [9:0] OPEN_OP  = 10'b1110_1110_00;
  localparam logic [7:0] CLOSE_OP = 8'b1111_0000;

  logic [SEL_W-1:0] held_sel;

  wire [SEL_W-1:0] word_sel = instr_word[5:4];
  wire is_open  = instr_valid && (instr_word[15:6] == OPEN_OP);
  wire is_close = instr_valid && (instr_word[15:8] == CLOSE_OP);
  wire sel_ok   = int'(word_sel) < PTR_COUNT;
  wire hi_wr    = is_open && sel_ok;
  wire lo_wr    = is_close && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      held_sel <= '0;
      sel_err  <= 1'b0;
    end else begin
      sel_err <= is_open && !sel_ok;
      if (instr_valid) begin
        busy <= hi_wr;
        if (hi_wr) held_sel <= word_sel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_hi <= '0;
      ptr_lo <= '0;
    end else begin
      for (int i = 0; i < PTR_COUNT; i++) begin
        if (hi_wr && int'(word_sel) == i) ptr_hi[i] <= {4'h0, instr_word[3:0]};
        if (lo_wr && int'(held_sel) == i) ptr_lo[i] <= instr_word[7:0];
      end
    end
  end

  // R2
  genvar g;
  for (g = 0; g < PTR_COUNT; g++) begin : g_nib
    hi_nibble_zero_chk: assert property (@(posedge clk) disable iff (rst)
      ptr_hi[g][7:4] == 4'h0);
  end

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(instr_valid));

  // R4
  close_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && instr_valid && instr_word[15:8] == CLOSE_OP) |=> !busy);

  // R6
  err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    sel_err |-> (!busy && $stable(ptr_hi) && $stable(ptr_lo)));

  // R7
  stray_close_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && instr_valid && instr_word[15:12] == 4'hF)
      |=> ($stable(ptr_hi) && $stable(ptr_lo) && !busy));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> ($stable(ptr_hi) && $stable(ptr_lo) && $stable(busy)));
endmodule

// File: tb/ptr_literal_loader_tb.sv
module ptr_literal_loader_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic [2:0][7:0] ptr_hi, ptr_lo;
  logic busy, sel_err;

  int tests = 0, fails = 0;
  logic [7:0] exp_hi [3];
  logic [7:0] exp_lo [3];
  bit exp_busy = 0, exp_err = 0;
  int exp_sel = 0;

  always #5 clk = ~clk;

  ptr_literal_loader #(.PTR_COUNT(3)) dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .ptr_hi(ptr_hi), .ptr_lo(ptr_lo), .busy(busy), .sel_err(sel_err));

  task automatic check(input string req);
    bit bad = 0;
    tests++;
    for (int i = 0; i < 3; i++)
      if (ptr_hi[i] !== exp_hi[i] || ptr_lo[i] !== exp_lo[i]) bad = 1;
    if (busy !== exp_busy || sel_err !== exp_err) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s: hi=%h %h %h lo=%h %h %h busy=%b err=%b exp hi=%h %h %h lo=%h %h %h busy=%b err=%b",
        req, ptr_hi[0], ptr_hi[1], ptr_hi[2], ptr_lo[0], ptr_lo[1], ptr_lo[2], busy, sel_err,
        exp_hi[0], exp_hi[1], exp_hi[2], exp_lo[0], exp_lo[1], exp_lo[2], exp_busy, exp_err);
    end
  endtask

  task automatic do_reset(input string req);
    @(negedge clk); rst = 1'b1; instr_valid = 1'b0;
    @(posedge clk); #1; rst = 1'b0;
    for (int i = 0; i < 3; i++) begin exp_hi[i] = 8'h00; exp_lo[i] = 8'h00; end
    exp_busy = 0; exp_err = 0;
    check(req);
  endtask

  task automatic step(input bit v, input logic [15:0] w, input string req);
    @(negedge clk); instr_valid = v; instr_word = w;
    @(posedge clk); #1; instr_valid = 1'b0;
    exp_err = 0;
    if (v) begin
      if (w[15:6] == 10'b1110_1110_00) begin
        if (w[5:4] != 2'd3) begin
          exp_hi[w[5:4]] = {4'h0, w[3:0]}; exp_busy = 1; exp_sel = int'(w[5:4]);
        end else begin
          exp_err = 1; exp_busy = 0;
        end
      end else if (w[15:8] == 8'hF0 && exp_busy) begin
        exp_lo[exp_sel] = w[7:0]; exp_busy = 0;
      end else begin
        exp_busy = 0;
      end
    end
    check(req);
  endtask

  function automatic logic [15:0] open_w(input int sel, input int lit);
    return {10'b1110_1110_00, 2'(sel), 4'(lit >> 8)};
  endfunction

  function automatic logic [15:0] close_w(input int lit);
    return {8'hF0, 8'(lit)};
  endfunction

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset("R1 reset state");
    step(1, open_w(2, 12'h3AB), "R5 example high");
    step(1, close_w(12'h3AB), "R5 example low");
    if (ptr_hi[2] !== 8'h03 || ptr_lo[2] !== 8'hAB) begin
      fails++;
      $display("FAIL R5: hi=%h lo=%h expected 03 ab", ptr_hi[2], ptr_lo[2]);
    end
    tests++;
    for (int s = 0; s < 3; s++)
      for (int lit = 0; lit < 4096; lit++) begin
        step(1, open_w(s, lit), "R2 R3 sweep open");
        if ((lit % 512) == 7) step(0, close_w(lit), "R8 gap while busy");
        step(1, close_w(lit), "R4 sweep close");
      end
    for (int x = 0; x < 16; x++) begin
      step(1, open_w(3, x), "R6 illegal select");
      step(0, 16'h0000, "R10 pulse ends");
    end
    step(1, open_w(3, 5), "R6 back to back 1");
    step(1, open_w(3, 6), "R6 back to back 2");
    step(1, open_w(1, 9), "R10 legal after err");
    step(1, open_w(3, 2), "R6 illegal cancels pending");
    step(1, close_w(8'h55), "R7 close after cancel");
    for (int k = 0; k < 16; k++) step(1, {4'hF, 4'(k), 8'hC3}, "R7 stray 1111 word");
    step(1, open_w(0, 12'h7FF), "R9 open");
    step(1, 16'h0000, "R9 other word cancels");
    step(1, close_w(8'h12), "R9 close ignored");
    step(1, open_w(1, 12'h123), "R9 open first");
    step(1, open_w(0, 12'hABC), "R9 open restarts");
    step(1, close_w(12'hABC), "R9 close lands on new select");
    step(1, open_w(2, 12'h456), "R9 open");
    step(1, 16'hF1AA, "R9 wrong 1111 form cancels");
    step(0, 16'hF000, "R8 invalid close form");
    step(1, open_w(1, 12'hFED), "R3 open before reset");
    do_reset("R1 reset mid load");
    step(1, close_w(8'h99), "R7 close after reset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule